// File: doc/BRIEF.md
# Repetitive Inrush Duty Limiter

This block guards a switched input stage against overheating when an abnormal signal would set off one inrush pulse after another. A strobe tells it, once per clock, whether inrush current is flowing. The block keeps a sliding record of how many of the most recent window ticks had the strobe high. When that count passes a threshold picked by a 2-bit select, it drops its enable output for a fixed lockout so that no further inrush pulses can start. It also sends a one-cycle event toward a fault flag register.

The window is made of `N_BUCKETS` equal buckets of `BUCKET_TICKS` clocks each, kept in a ring. A running sum is updated as each bucket closes and the oldest one falls out. The window is therefore `N_BUCKETS*BUCKET_TICKS` ticks long. The lockout length `LOCK_TICKS` defaults to the window length. Both lengths are counted in clock ticks, so a simulation can scale a multi-second real period down to a few hundred clocks.

Top module: `inrush_duty_limiter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `inrush_en` is 1 and `trip_evt` is 0, and the window history is empty.
- R2: The select encodes the threshold as follows: 2'b01 is WINDOW/64, 2'b10 is WINDOW/32 and 2'b11 is WINDOW/16, where WINDOW = N_BUCKETS*BUCKET_TICKS. A trip happens when the strobe-high count over the window exceeds the selected threshold.
- R3: A window count exactly equal to the threshold does not trip; the test is strictly greater-than.
- R4: The count is evaluated only when a bucket closes. A bucket closes every BUCKET_TICKS-th clock edge of monitoring, counted from reset or from the end of a lockout. The count covers the last N_BUCKETS closed buckets, so strobe-high ticks older than that no longer count.
- R5: With the select at 2'b00 no trip occurs and no event is raised, whatever the strobe does.
- R6: A trip raises `trip_evt` for exactly one cycle. `inrush_en` falls on the same clock edge.
- R7: After a trip, `inrush_en` stays low for exactly LOCK_TICKS cycles and then returns to 1.
- R8: Strobe activity during a lockout is not counted. When the lockout ends, the window history and the partial bucket are cleared, so stale history cannot cause a retrip.
- R9: The trip decision uses the select value sampled at the closing edge. Raising the select from off while the history is full trips at the next bucket close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inrush_on | input | 1 | High in each cycle that inrush current flows |
| duty_sel | input | 2 | Threshold select: 00 off, 01 1/64, 10 1/32, 11 1/16 of the window |
| inrush_en | output | 1 | Permission for new inrush pulses; low during a lockout |
| trip_evt | output | 1 | One-cycle event for the fault flag register on each trip |

## Verification
The bench puts a window count exactly on each threshold and then one above it. A comparison written as greater-or-equal would trip one pulse too early. It spaces strobe pulses further apart than the window, so a ring that never drops its oldest bucket would add up stale ticks and trip. It holds the strobe high through a lockout and then stops it just as the enable returns. A design that counts during the lockout, or that does not clear its history on exit, then trips a second time. It also raises the select from off over a full history and measures the lockout length, which exposes off-by-one errors in the lockout counter.

// File: rtl/inrush_lim_pkg.sv
package inrush_lim_pkg;

   typedef enum logic [1:0] {
      DUTY_OFF = 2'b00,
      DUTY_64  = 2'b01,
      DUTY_32  = 2'b10,
      DUTY_16  = 2'b11
   } duty_sel_e;

   // Allowed window tick count for a given select; window is the window length in ticks.
   function automatic int unsigned duty_limit(duty_sel_e sel, int unsigned window);
      case (sel)
         DUTY_64: return window >> 6;
         DUTY_32: return window >> 5;
         DUTY_16: return window >> 4;
         default: return window;
      endcase
   endfunction

endpackage

// File: rtl/inrush_bucket_ring.sv
module inrush_bucket_ring #(
   parameter int N_BUCKETS    = 8,
   parameter int BUCKET_TICKS = 16,
   parameter int SUM_W        = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             active,
   input  logic             strobe,
   output logic             close,
   output logic [SUM_W-1:0] sum_next
);
   localparam int CNT_W = $clog2(BUCKET_TICKS + 1);
   localparam int PTR_W = (N_BUCKETS > 1) ? $clog2(N_BUCKETS) : 1;

   logic [CNT_W-1:0] tick_q;
   logic [CNT_W-1:0] cur_q;
   logic [CNT_W-1:0] cur_total;
   logic [CNT_W-1:0] bucket_q [N_BUCKETS];
   logic [CNT_W-1:0] oldest;
   logic [PTR_W-1:0] wp_q;
   logic [SUM_W-1:0] sum_q;

   assign close     = active && (tick_q == CNT_W'(BUCKET_TICKS - 1));
   assign cur_total = cur_q + CNT_W'(strobe);
   assign sum_next  = sum_q - SUM_W'(oldest) + SUM_W'(cur_total);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= '0;
         cur_q  <= '0;
      end else if (clear) begin
         tick_q <= '0;
         cur_q  <= '0;
      end else if (active) begin
         if (close) begin
            tick_q <= '0;
            cur_q  <= '0;
         end else begin
            tick_q <= tick_q + 1'b1;
            cur_q  <= cur_total;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sum_q <= '0;
      else if (clear)  sum_q <= '0;
      else if (close)  sum_q <= sum_next;
   end

   generate
      if (N_BUCKETS == 1) begin : g_single
         assign wp_q   = '0;
         assign oldest = bucket_q[0];
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      wp_q <= '0;
            else if (clear)  wp_q <= '0;
            else if (close)  wp_q <= (wp_q == PTR_W'(N_BUCKETS - 1)) ? '0 : wp_q + 1'b1;
         end
         assign oldest = bucket_q[wp_q];
      end

      for (genvar g = 0; g < N_BUCKETS; g++) begin : g_bucket
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              bucket_q[g] <= '0;
            else if (clear)                          bucket_q[g] <= '0;
            else if (close && wp_q == PTR_W'(g))     bucket_q[g] <= cur_total;
         end
      end
   endgenerate

endmodule

// File: rtl/inrush_duty_cmp.sv
module inrush_duty_cmp
   import inrush_lim_pkg::*;
#(
   parameter int WINDOW = 128,
   parameter int SUM_W  = 8
) (
   input  logic             valid,
   input  logic [1:0]       sel,
   input  logic [SUM_W-1:0] sum,
   output logic             trip
);
   localparam logic [SUM_W-1:0] LIM_64 = SUM_W'(duty_limit(DUTY_64, WINDOW));
   localparam logic [SUM_W-1:0] LIM_32 = SUM_W'(duty_limit(DUTY_32, WINDOW));
   localparam logic [SUM_W-1:0] LIM_16 = SUM_W'(duty_limit(DUTY_16, WINDOW));

   duty_sel_e        mode;
   logic [SUM_W-1:0] limit;

   assign mode = duty_sel_e'(sel);

   always_comb begin
      case (mode)
         DUTY_64: limit = LIM_64;
         DUTY_32: limit = LIM_32;
         DUTY_16: limit = LIM_16;
         default: limit = '1;
      endcase
   end

   assign trip = valid && (mode != DUTY_OFF) && (sum > limit);

endmodule

// File: rtl/inrush_lock_timer.sv
module inrush_lock_timer #(
   parameter int LOCK_TICKS = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic locked,
   output logic done
);
   localparam int LW = $clog2(LOCK_TICKS + 1);

   logic [LW-1:0] cnt_q;
   logic          locked_q;

   assign locked = locked_q;
   assign done   = locked_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         cnt_q    <= '0;
      end else if (start) begin
         locked_q <= 1'b1;
         cnt_q    <= LW'(LOCK_TICKS - 1);
      end else if (done) begin
         locked_q <= 1'b0;
      end else if (locked_q) begin
         cnt_q    <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/inrush_duty_limiter.sv
module inrush_duty_limiter #(
   parameter int N_BUCKETS    = 8,
   parameter int BUCKET_TICKS = 16,
   parameter int LOCK_TICKS   = N_BUCKETS * BUCKET_TICKS
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inrush_on,
   input  logic [1:0] duty_sel,
   output logic       inrush_en,
   output logic       trip_evt
);
   localparam int WINDOW = N_BUCKETS * BUCKET_TICKS;
   localparam int SUM_W  = $clog2(WINDOW + 1);

   generate
      if (N_BUCKETS < 1)    begin : g_bad_n   $error("N_BUCKETS must be at least 1");    end
      if (BUCKET_TICKS < 1) begin : g_bad_bt  $error("BUCKET_TICKS must be at least 1"); end
      if (WINDOW < 64)      begin : g_bad_win $error("window must span at least 64 ticks"); end
      if (LOCK_TICKS < 1)   begin : g_bad_lk  $error("LOCK_TICKS must be at least 1");   end
   endgenerate

   logic             locked;
   logic             lock_done;
   logic             close;
   logic             trip_now;
   logic [SUM_W-1:0] sum_next;
   logic             evt_q;

   inrush_bucket_ring #(
      .N_BUCKETS   (N_BUCKETS),
      .BUCKET_TICKS(BUCKET_TICKS),
      .SUM_W       (SUM_W)
   ) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (lock_done),
      .active  (!locked),
      .strobe  (inrush_on),
      .close   (close),
      .sum_next(sum_next)
   );

   inrush_duty_cmp #(
      .WINDOW(WINDOW),
      .SUM_W (SUM_W)
   ) u_cmp (
      .valid(close),
      .sel  (duty_sel),
      .sum  (sum_next),
      .trip (trip_now)
   );

   inrush_lock_timer #(
      .LOCK_TICKS(LOCK_TICKS)
   ) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .start (trip_now),
      .locked(locked),
      .done  (lock_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= trip_now;
   end

   assign inrush_en = !locked;
   assign trip_evt  = evt_q;

endmodule

// File: rtl/inrush_lim_chk.sv
module inrush_lim_chk #(
   parameter int LOCK_TICKS = 128
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] duty_sel,
   input logic       inrush_en,
   input logic       trip_evt
);
   logic [31:0] low_run;
   logic        en_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run <= '0;
         en_prev <= 1'b1;
      end else begin
         en_prev <= inrush_en;
         low_run <= inrush_en ? '0 : low_run + 1;
      end
   end

   // R6: the event comes with the enable dropping
   assert_evt_drops_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trip_evt |-> !inrush_en);

   // R6: the event lasts a single cycle
   assert_evt_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trip_evt |=> !trip_evt);

   // R5: off setting never produces an event
   assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_sel == 2'b00) |=> !trip_evt);

   // R7: enable comes back after exactly the lockout length
   assert_lock_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inrush_en && !en_prev) |-> (low_run == 32'(LOCK_TICKS)));

   // R8: no new event while a lockout is already running
   assert_no_evt_in_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!inrush_en && !en_prev) |-> !trip_evt);

endmodule

bind inrush_duty_limiter inrush_lim_chk #(
   .LOCK_TICKS(LOCK_TICKS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .duty_sel (duty_sel),
   .inrush_en(inrush_en),
   .trip_evt (trip_evt)
);

// File: tb/inrush_duty_limiter_bench.sv
`timescale 1ns/1ps
module inrush_duty_limiter_bench;
   localparam int NB  = 8;
   localparam int BT  = 16;
   localparam int WIN = NB * BT;
   localparam int LK  = WIN;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       inrush_on = 1'b0;
   logic [1:0] duty_sel = 2'b00;
   logic       inrush_en;
   logic       trip_evt;

   int checks = 0;
   int fails  = 0;
   int trips  = 0;
   int low_run = 0;
   int last_low = 0;
   int cyc = 0;
   string cur_req = "R1";

   // reference model state
   int  hist[$];
   int  cur = 0, tick = 0, lock_left = 0;
   bit  locked = 0, exp_en = 1, exp_evt = 0;

   always #2.5 clk = ~clk;

   inrush_duty_limiter #(.N_BUCKETS(NB), .BUCKET_TICKS(BT), .LOCK_TICKS(LK)) u_inrush_duty_limiter (
      .clk(clk), .rst_n(rst_n), .inrush_on(inrush_on), .duty_sel(duty_sel),
      .inrush_en(inrush_en), .trip_evt(trip_evt));

   function automatic int lim(logic [1:0] s);
      if (s == 2'b01) return WIN / 64;
      if (s == 2'b10) return WIN / 32;
      return WIN / 16;
   endfunction

   task automatic model_clear();
      hist.delete();
      for (int i = 0; i < NB; i++) hist.push_back(0);
      cur = 0; tick = 0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model_clear();
         locked = 0; lock_left = 0; exp_en = 1; exp_evt = 0;
      end else if (locked) begin
         exp_evt = 0;
         if (lock_left == 0) begin locked = 0; exp_en = 1; model_clear(); end
         else lock_left--;
      end else begin
         exp_evt = 0;
         cur += int'(inrush_on);
         tick++;
         if (tick == BT) begin
            int s;
            tick = 0;
            hist.push_back(cur);
            void'(hist.pop_front());
            cur = 0;
            s = 0;
            foreach (hist[i]) s += hist[i];
            if (duty_sel != 2'b00 && s > lim(duty_sel)) begin
               locked = 1; lock_left = LK - 1; exp_en = 0; exp_evt = 1;
            end
         end
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(inrush_en == exp_en, {cur_req, " inrush_en"}, int'(inrush_en), int'(exp_en));
         chk(trip_evt == exp_evt, {cur_req, " trip_evt"}, int'(trip_evt), int'(exp_evt));
         if (trip_evt) begin
            trips++;
            chk(inrush_en == 1'b0, "R6 enable low with event", int'(inrush_en), 0);
         end
         if (!inrush_en) low_run++;
         else begin
            if (low_run > 0) last_low = low_run;
            low_run = 0;
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; inrush_on = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      trips = 0; low_run = 0; last_low = 0;
   endtask

   task automatic pulse(int n);
      @(negedge clk); inrush_on = 1'b1;
      repeat (n) @(negedge clk);
      inrush_on = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      rst_n = 1'b0;
      idle(2);
      chk(inrush_en == 1'b1, "R1 en in reset", int'(inrush_en), 1);
      chk(trip_evt == 1'b0, "R1 evt in reset", int'(trip_evt), 0);
      rst_n = 1'b1;
      idle(1);
      chk(inrush_en == 1'b1 && trip_evt == 1'b0, "R1 after release", int'(inrush_en), 1);

      // R5: off setting with strobe stuck high
      cur_req = "R5"; duty_sel = 2'b00;
      @(negedge clk); inrush_on = 1'b1;
      idle(400);
      chk(trips == 0, "R5 no trips when off", trips, 0);
      chk(last_low == 0 && low_run == 0, "R5 enable never low", low_run, 0);

      // R9: select raised over full history
      cur_req = "R9"; duty_sel = 2'b11;
      idle(20);
      inrush_on = 1'b0;
      chk(trips == 1, "R9 trip after select raised", trips, 1);

      // R7: lockout length
      cur_req = "R7";
      idle(LK + 10);
      chk(last_low == LK, "R7 lockout length", last_low, LK);

      // R3 then R2 at 1/64
      do_reset(); cur_req = "R3"; duty_sel = 2'b01;
      pulse(lim(2'b01)); idle(300);
      chk(trips == 0, "R3 equal count at 1/64 no trip", trips, 0);
      cur_req = "R2";
      pulse(lim(2'b01) + 1); idle(40);
      chk(trips == 1, "R2 above 1/64 trips", trips, 1);

      // R3 then R2 at 1/32
      do_reset(); cur_req = "R3"; duty_sel = 2'b10;
      pulse(lim(2'b10)); idle(300);
      chk(trips == 0, "R3 equal count at 1/32 no trip", trips, 0);
      cur_req = "R2";
      pulse(lim(2'b10) + 1); idle(40);
      chk(trips == 1, "R2 above 1/32 trips", trips, 1);

      // R3 then R2 at 1/16
      do_reset(); cur_req = "R3"; duty_sel = 2'b11;
      pulse(lim(2'b11)); idle(300);
      chk(trips == 0, "R3 equal count at 1/16 no trip", trips, 0);
      cur_req = "R2";
      pulse(lim(2'b11) + 1); idle(40);
      chk(trips == 1, "R2 above 1/16 trips", trips, 1);

      // R4: old ticks leave the window, recent ones add up
      do_reset(); cur_req = "R4"; duty_sel = 2'b01;
      pulse(2); idle(WIN + 2 * BT);
      pulse(2); idle(40);
      chk(trips == 0, "R4 expired ticks not counted", trips, 0);
      pulse(1); idle(40);
      chk(trips == 1, "R4 ticks inside window add up", trips, 1);

      // R8: strobe during lockout ignored, history cleared after
      do_reset(); cur_req = "R8"; duty_sel = 2'b11;
      pulse(lim(2'b11) + 1);
      @(negedge clk); inrush_on = 1'b1;
      while (inrush_en) @(negedge clk);
      while (!inrush_en) @(negedge clk);
      inrush_on = 1'b0;
      idle(WIN + 40);
      chk(trips == 1, "R8 no retrip after lockout", trips, 1);

      // R2: mixed random traffic against the model
      do_reset(); cur_req = "R2 random";
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (k % 500 == 0) duty_sel = 2'($urandom_range(0, 3));
         inrush_on = ($urandom_range(0, 15) == 0);
      end
      inrush_on = 1'b0;
      idle(5);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule